// File: doc/BRIEF.md
# Sector Sync Detector and Byte Position Counter

This block watches a stream of received disc bytes, each carrying an error flag, and finds where each sector begins. It keeps the position of every byte inside its sector. A sector boundary can come from two places. One is the 12-byte sync pattern in the data: one 00h byte, then ten FFh bytes, then one 00h byte. The other is a pulse on an external sync input that arrives together with a byte. Once the block has locked to a sector, it can insert a sector start at the expected position when no sync shows up there.

The sector length depends on a two-bit mode. A full raw sector is 2352 bytes. The other modes use a 2064-byte count, and one of them leaves flagged bytes out of the count. The block also collects error flags for the four sub-header bytes into four status bits. A configuration bit decides whether only the first copy of the sub-header feeds these bits, or both copies do. A sticky status bit records any sync that arrived while locked but away from the expected boundary.

Bytes enter on a valid/ready interface. The block never applies back-pressure: `in_ready` is high whenever reset is released, so a byte is accepted on every clock edge where `in_valid` is high. The results for an accepted byte appear on the outputs one clock later, qualified by `out_valid`. Configuration inputs should only change while no byte is being presented.

Top module: `sector_sync_tracker`

## Requirements
- R1: During and after reset, before any byte is accepted, `out_valid`, `out_start`, `out_interp`, `out_idx`, `sh_err` and `misplaced` are all 0, and `in_ready` is 1.
- R2: With `cfg_ext_src`=0, the accepted byte that completes 00h, ten FFh, 00h produces `out_start`=1 with `out_idx`=0 on the following cycle. A near miss (00h, nine FFh, 00h) produces no start. After reset the index counts up from 0 on every accepted byte.
- R3: With `cfg_ext_src`=1, a byte accepted with `ext_sync`=1 is a sector start with index 0, and the data pattern starts nothing. With `cfg_ext_src`=0, `ext_sync` has no effect.
- R4: Each counted byte after a start takes the next index (start byte = 0). The expected boundary falls after L counted bytes, where `cfg_mod` gives L: 00 → 2352, 01 → 2064, 10 → 2064, and 11 (reserved) → 2352.
- R5: In mode 10, a byte accepted with `in_flag`=1 is not counted. It reports the index that the next counted byte will carry, and it cannot be an expected boundary.
- R6: When locked, if the byte at the expected boundary carries no sync and `cfg_interp`=1, that byte is reported with `out_start`=1, `out_interp`=1 and `out_idx`=0.
- R7: With `cfg_interp`=0, a missed boundary produces no start. The index keeps counting (the boundary byte reports L) and lock is dropped, so the next detected sync does not set `misplaced`.
- R8: A sync detected exactly at the expected boundary gives `out_start`=1 with `out_interp`=0 and leaves `misplaced` unchanged.
- R9: A sync detected while locked but not at the expected boundary is still accepted as a start with index 0. It also sets `misplaced`, which stays 1 until reset.
- R10: Bit k of `sh_err` (k = 0..3) is set when a counted byte with index 5+k arrives flagged. When `cfg_copy1`=0, a flagged byte with index 9+k also sets bit k. When `cfg_copy1`=1, bytes 9..12 are ignored.
- R11: `sh_err` is cleared on every sector start, whether detected or interpolated.
- R12: On a cycle with `in_valid`=0, `out_valid` is 0 on the next cycle and the byte position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented |
| in_ready | output | 1 | Byte accepted when high; always 1 out of reset |
| in_data | input | 8 | Received byte |
| in_flag | input | 1 | Error flag for the byte |
| ext_sync | input | 1 | External sector sync marker for this byte |
| cfg_mod | input | 2 | Sector length mode (00 2352, 01 2064, 10 2064 skipping flagged, 11 as 00) |
| cfg_interp | input | 1 | Enable insertion of a missing sync |
| cfg_ext_src | input | 1 | 1: sync from `ext_sync`; 0: from data pattern |
| cfg_copy1 | input | 1 | 1: only the first sub-header copy feeds `sh_err` |
| out_valid | output | 1 | Results for one accepted byte |
| out_start | output | 1 | Byte is the first of a sector |
| out_interp | output | 1 | The start was inserted, not detected |
| out_idx | output | 12 | Byte position in the sector |
| sh_err | output | 4 | Sub-header byte error status |
| misplaced | output | 1 | Sticky: a sync arrived off the expected boundary |

## Verification
Sync detection and interpolation compete in one cycle when a sync pattern (or an external pulse) completes exactly on the expected boundary while interpolation is enabled. The bench builds this by sending a full sector of filler whose last twelve bytes form the pattern. It then requires a start with the interpolated flag low and `misplaced` still clear. A second overlap is a sector start arriving in the same cycle as a sub-header flag update. The bench judges it by checking that the error bits read zero right after each start, even though flagged sub-header bytes filled them during the sector before.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    MOD_FULL       = 2'b00,
    MOD_SHORT      = 2'b01,
    MOD_SHORT_SKIP = 2'b10,
    MOD_RSVD       = 2'b11
  } mod_e;

  typedef struct packed {
    logic start;
    logic interp;
    logic skip;
    logic misplace;
  } pos_ev_t;
endpackage

// File: rtl/sst_sync_match.sv
module sst_sync_match #(
  parameter int SYNC_LEN = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v,
  input  logic [7:0] byte_i,
  output logic       hit
);
  localparam int ST_W = $clog2(SYNC_LEN);
  localparam logic [ST_W-1:0] LAST = ST_W'(SYNC_LEN - 1);

  logic [ST_W-1:0] st, st_n;
  logic mark, fill;

  always_comb begin
    mark = (byte_i == 8'h00);
    fill = (byte_i == 8'hFF);
    hit  = v && (st == LAST) && mark;
    if (st == LAST || st == '0) st_n = mark ? ST_W'(1) : '0;
    else if (fill)              st_n = st + ST_W'(1);
    else                        st_n = mark ? ST_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  st <= '0;
    else if (v)  st <= st_n;
  end

  // R2
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> st == ST_W'(1));
endmodule

// File: rtl/sst_pos_counter.sv
module sst_pos_counter
  import sst_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int LEN_FULL  = 2352,
  parameter int LEN_SHORT = 2064
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v,
  input  logic             det,
  input  logic             flag,
  input  mod_e             mode,
  input  logic             interp_en,
  output pos_ev_t          ev,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] L_FULL  = IDX_W'(LEN_FULL);
  localparam logic [IDX_W-1:0] L_SHORT = IDX_W'(LEN_SHORT);
  localparam logic [IDX_W-1:0] CNT_MAX = '1;

  logic [IDX_W-1:0] cnt, len;
  logic locked, skip_raw, at_edge;

  always_comb begin
    len      = (mode == MOD_SHORT || mode == MOD_SHORT_SKIP) ? L_SHORT : L_FULL;
    skip_raw = v && (mode == MOD_SHORT_SKIP) && flag;
    at_edge  = v && locked && !skip_raw && (cnt == len);
    ev.start    = v && (det || (at_edge && interp_en));
    ev.interp   = ev.start && !det;
    ev.skip     = skip_raw && !ev.start;
    ev.misplace = v && det && locked && (cnt != len);
    idx = ev.start ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (v) begin
      if (ev.start) begin
        cnt    <= IDX_W'(1);
        locked <= 1'b1;
      end else if (!ev.skip) begin
        if (cnt != CNT_MAX) cnt <= cnt + IDX_W'(1);
        if (at_edge) locked <= 1'b0;
      end
    end
  end

  // R6
  interp_only_when_nodet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.interp |-> !det && interp_en);
  // R7
  missed_edge_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && !det && !interp_en) |=> !locked);
endmodule

// File: rtl/sst_subhdr_errs.sv
module sst_subhdr_errs #(
  parameter int IDX_W   = 12,
  parameter int SH_BASE = 5,
  parameter int SH_N    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v,
  input  logic             start,
  input  logic             skip,
  input  logic             flag,
  input  logic             copy1,
  input  logic [IDX_W-1:0] idx,
  output logic [SH_N-1:0]  errs
);
  logic counted;
  assign counted = v && !start && !skip && flag;

  for (genvar k = 0; k < SH_N; k++) begin : g_bit
    localparam logic [IDX_W-1:0] P1 = IDX_W'(SH_BASE + k);
    localparam logic [IDX_W-1:0] P2 = IDX_W'(SH_BASE + SH_N + k);
    logic hit_k;
    assign hit_k = counted && (idx == P1 || (!copy1 && idx == P2));
    always_ff @(posedge clk) begin
      if (!rst_n)     errs[k] <= 1'b0;
      else if (start) errs[k] <= 1'b0;
      else if (hit_k) errs[k] <= 1'b1;
    end
  end

  // R11
  sh_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> errs == '0);
endmodule

// File: rtl/sector_sync_tracker.sv
module sector_sync_tracker
  import sst_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int LEN_FULL  = 2352,
  parameter int LEN_SHORT = 2064,
  parameter int SYNC_LEN  = 12,
  parameter int SH_N      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_flag,
  input  logic             ext_sync,
  input  logic [1:0]       cfg_mod,
  input  logic             cfg_interp,
  input  logic             cfg_ext_src,
  input  logic             cfg_copy1,
  output logic             out_valid,
  output logic             out_start,
  output logic             out_interp,
  output logic [IDX_W-1:0] out_idx,
  output logic [SH_N-1:0]  sh_err,
  output logic             misplaced
);
  localparam int SH_BASE = SYNC_LEN - 7;

  logic v, pat_hit, det;
  pos_ev_t ev;
  logic [IDX_W-1:0] idx;

  assign in_ready = 1'b1;
  assign v   = in_valid && in_ready;
  assign det = cfg_ext_src ? (v && ext_sync) : pat_hit;

  sst_sync_match #(.SYNC_LEN(SYNC_LEN)) u_match (
    .clk(clk), .rst_n(rst_n), .v(v), .byte_i(in_data), .hit(pat_hit));

  sst_pos_counter #(.IDX_W(IDX_W), .LEN_FULL(LEN_FULL), .LEN_SHORT(LEN_SHORT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .v(v), .det(det), .flag(in_flag),
    .mode(mod_e'(cfg_mod)), .interp_en(cfg_interp), .ev(ev), .idx(idx));

  sst_subhdr_errs #(.IDX_W(IDX_W), .SH_BASE(SH_BASE), .SH_N(SH_N)) u_sh (
    .clk(clk), .rst_n(rst_n), .v(v), .start(ev.start), .skip(ev.skip),
    .flag(in_flag), .copy1(cfg_copy1), .idx(idx), .errs(sh_err));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_start  <= 1'b0;
      out_interp <= 1'b0;
      out_idx    <= '0;
      misplaced  <= 1'b0;
    end else begin
      out_valid <= v;
      if (v) begin
        out_start  <= ev.start;
        out_interp <= ev.interp;
        out_idx    <= idx;
      end else begin
        out_start  <= 1'b0;
        out_interp <= 1'b0;
      end
      if (ev.misplace) misplaced <= 1'b1;
    end
  end

  // R6
  interp_implies_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_interp |-> out_start);
  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_idx == '0 && out_valid);
  // R9
  misplaced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misplaced |=> misplaced);
  // R12
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_start);
endmodule

// File: tb/tb_sector_sync_tracker.sv
module tb_sector_sync_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_flag = 1'b0, ext_sync = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cfg_mod = 2'b00;
  logic cfg_interp = 1'b1, cfg_ext_src = 1'b0, cfg_copy1 = 1'b0;
  logic in_ready, out_valid, out_start, out_interp, misplaced;
  logic [11:0] out_idx;
  logic [3:0] sh_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sector_sync_tracker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flag(in_flag), .ext_sync(ext_sync),
    .cfg_mod(cfg_mod), .cfg_interp(cfg_interp), .cfg_ext_src(cfg_ext_src),
    .cfg_copy1(cfg_copy1), .out_valid(out_valid), .out_start(out_start),
    .out_interp(out_interp), .out_idx(out_idx), .sh_err(sh_err),
    .misplaced(misplaced));

  // rows: {byte, expected start, expected index}
  localparam logic [20:0] VEC [24] = '{
    {8'h00,1'b0,12'd0},  {8'hFF,1'b0,12'd1},  {8'hFF,1'b0,12'd2},  {8'hFF,1'b0,12'd3},
    {8'hFF,1'b0,12'd4},  {8'hFF,1'b0,12'd5},  {8'hFF,1'b0,12'd6},  {8'hFF,1'b0,12'd7},
    {8'hFF,1'b0,12'd8},  {8'hFF,1'b0,12'd9},  {8'h00,1'b0,12'd10}, {8'hFF,1'b0,12'd11},
    {8'hFF,1'b0,12'd12}, {8'hFF,1'b0,12'd13}, {8'hFF,1'b0,12'd14}, {8'hFF,1'b0,12'd15},
    {8'hFF,1'b0,12'd16}, {8'hFF,1'b0,12'd17}, {8'hFF,1'b0,12'd18}, {8'hFF,1'b0,12'd19},
    {8'hFF,1'b0,12'd20}, {8'h00,1'b1,12'd0},  {8'h12,1'b0,12'd1},  {8'h34,1'b0,12'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic f, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_flag = f; ext_sync = e;
    @(posedge clk); #2;
  endtask

  task automatic idle(input logic [1:0] m, input logic ie, input logic es, input logic c1);
    @(negedge clk);
    in_valid = 1'b0; ext_sync = 1'b0; in_flag = 1'b0;
    cfg_mod = m; cfg_interp = ie; cfg_ext_src = es; cfg_copy1 = c1;
    @(posedge clk); #2;
  endtask

  // packed view: start*8192 + interp*4096 + idx
  task automatic send_chk(input logic [7:0] b, input logic f, input logic e,
                          input logic es, input logic ei, input int eidx, input string tag);
    send(b, f, e);
    chk(out_valid && out_start == es && out_interp == ei && out_idx == 12'(eidx), tag,
        int'(out_start) * 8192 + int'(out_interp) * 4096 + int'(out_idx),
        int'(es) * 8192 + int'(ei) * 4096 + eidx);
  endtask

  task automatic fill(input int first, input int last, input int f1, input int f2,
                      input string tag);
    int errs = 0, act = 0, exp = 0;
    for (int i = first; i <= last; i++) begin
      send(8'h5A, (i == f1 || i == f2), 1'b0);
      if (out_start || out_idx != 12'(i)) begin
        if (errs == 0) begin act = int'(out_idx); exp = i; end
        errs++;
      end
    end
    chk(errs == 0, tag, act, exp);
  endtask

  task automatic sync_head(input int first, input string tag);
    int errs = 0, act = 0, exp = 0;
    for (int i = 0; i < 11; i++) begin
      send((i == 0) ? 8'h00 : 8'hFF, 1'b0, 1'b0);
      if (out_start || out_idx != 12'(first + i)) begin
        if (errs == 0) begin act = int'(out_idx); exp = first + i; end
        errs++;
      end
    end
    chk(errs == 0, tag, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    chk(!out_valid && !out_start && out_idx == 0 && sh_err == 0 && !misplaced,
        "R1 reset outputs", int'(out_valid) + int'(out_idx), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(in_ready == 1'b1 && !misplaced && sh_err == 0, "R1 ready after reset",
        int'(in_ready), 1);

    // R2 pattern detection table, near miss first
    for (int r = 0; r < 24; r++) begin
      send(VEC[r][20:13], 1'b0, 1'b0);
      chk(out_valid && out_start == VEC[r][12] && out_idx == VEC[r][11:0],
          $sformatf("R2 table row %0d", r), int'(out_start) * 8192 + int'(out_idx),
          int'(VEC[r][12]) * 8192 + int'(VEC[r][11:0]));
    end

    // R4/R10: full sector, sub-header flags at idx 6 and 11, both copies used
    fill(3, 2340, 6, 11, "R4 full-sector index");
    chk(sh_err == 4'b0110, "R10 both copies", int'(sh_err), 6);
    sync_head(2341, "R4 index up to 2351");
    // R8: detection and interpolation fall on the same byte
    send_chk(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R8 sync on boundary");
    chk(!misplaced, "R8 misplaced unchanged", int'(misplaced), 0);
    chk(sh_err == 0, "R11 clear on detected start", int'(sh_err), 0);

    // R10 first copy only, then R6 interpolation
    idle(2'b00, 1'b1, 1'b0, 1'b1);
    fill(1, 2351, 6, 11, "R4 sector two index");
    chk(sh_err == 4'b0010, "R10 first copy only", int'(sh_err), 2);
    send_chk(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R6 interpolated start");
    chk(sh_err == 0, "R11 clear on interpolated start", int'(sh_err), 0);

    // R7 no interpolation, then R9
    idle(2'b00, 1'b0, 1'b0, 1'b0);
    fill(1, 2351, -1, -1, "R7 sector index");
    send_chk(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 2352, "R7 missed boundary counts on");
    sync_head(2353, "R7 index past boundary");
    send_chk(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R7 resync after miss");
    chk(!misplaced, "R7 unlocked sync not misplaced", int'(misplaced), 0);
    fill(1, 99, -1, -1, "R9 short run");
    sync_head(100, "R9 head");
    send_chk(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R9 early sync accepted");
    chk(misplaced, "R9 misplaced set", int'(misplaced), 1);
    send_chk(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R9 index after resync");
    chk(misplaced, "R9 misplaced sticky", int'(misplaced), 1);

    // R4 mode 01
    idle(2'b01, 1'b1, 1'b0, 1'b0);
    fill(2, 2063, -1, -1, "R4 mode01 index");
    send_chk(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R4 mode01 length 2064");

    // R5 mode 10 skips flagged bytes
    idle(2'b10, 1'b1, 1'b0, 1'b0);
    fill(1, 99, -1, -1, "R5 mode10 index");
    send_chk(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 100, "R5 flagged byte not counted");
    fill(100, 2063, -1, -1, "R5 mode10 after skip");
    send_chk(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R5 mode10 boundary");

    // R4 reserved mode 11
    idle(2'b11, 1'b1, 1'b0, 1'b0);
    fill(1, 2351, -1, -1, "R4 mode11 index");
    send_chk(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R4 mode11 length 2352");

    // R3 external source
    idle(2'b00, 1'b1, 1'b1, 1'b0);
    sync_head(1, "R3 pattern head ext mode");
    send_chk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 12, "R3 pattern ignored");
    fill(13, 49, -1, -1, "R3 index");
    send_chk(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R3 ext pulse start");
    idle(2'b00, 1'b1, 1'b0, 1'b0);
    send_chk(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R3 ext ignored in pattern mode");

    // R12 idle cycle
    idle(2'b00, 1'b1, 1'b0, 1'b0);
    chk(!out_valid && !out_start, "R12 no output when idle", int'(out_valid), 0);
    send_chk(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 2, "R12 index held over idle");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule